// File: doc/BRIEF.md
# Robbed-Bit Signaling Transmit Inserter

This block writes per-channel signaling into an outgoing 24-channel T1 stream. A host loads signaling bits into twelve 8-bit registers. Each register holds one signaling letter for eight channels. At each multiframe boundary the block copies the whole bank into an internal shadow register. While the multiframe runs, it puts the shadow bit for each channel into the least significant bit of that channel's byte in the signaling frames. A sticky flag tells the host that a copy has just happened, so the bank is free to be rewritten.

A phase state machine controls when the copy happens and which letters are inserted. It has four states. `PH_WAIT` is the state after reset, before any copy has happened, and no insertion takes place in it. `PH_ESF` inserts four letters over a 24-frame multiframe. `PH_D4_AB` inserts the A/B register groups over a 12-frame multiframe. `PH_D4_CD` inserts the C/D register groups as the A/B bits of the following 12-frame multiframe.

The transitions are taken only on the boundary byte, which is frame index 0, channel index 0:
- **load-esf**: from any state when the mode input selects ESF. The bank is copied.
- **load-d4**: from `PH_WAIT`, `PH_ESF` or `PH_D4_CD` when the mode input selects D4. The bank is copied and the next state is `PH_D4_AB`.
- **advance-d4**: from `PH_D4_AB` when D4 is selected. No copy is made and the next state is `PH_D4_CD`.

Top module: `rbs_tx_inserter`

## Requirements
- R1: Register address k (0 to 11) holds signaling letter k/3 (0=A, 1=B, 2=C, 3=D) for channels (k mod 3)*8 to (k mod 3)*8+7, with bit b holding channel (k mod 3)*8+b. Writes to addresses 12 to 15 change nothing.
- R2: The shadow copy is taken only on a valid byte with frame index 0 and channel index 0. It uses the register values from before that clock edge. A write made in the same cycle, or later in the multiframe, takes effect only at the next copy.
- R3: In ESF, bit 0 of each channel byte in 0-based frames 5, 11, 17 and 23 is replaced by that channel's shadow letter A, B, C and D respectively. A copy is made at every ESF boundary.
- R4: In D4, frames 5 and 11 carry the first and second letter. In the multiframe that starts with a copy, these are the A and B groups. In the next multiframe they are the C and D groups, and no copy is made at that multiframe's boundary.
- R5: Bits 7 to 1 always pass unchanged. With the insertion enable low, the whole byte passes unchanged.
- R6: After reset, and until the first copy, every byte passes unchanged.
- R7: The multiframe flag is 0 after reset. It is set by every copy and stays set until a clear strobe. When a copy and a clear happen in the same cycle, the flag ends up set.
- R8: The mode input is sampled only at a boundary. Selecting ESF at any boundary, including the one that would otherwise be the no-copy D4 boundary, makes a copy at once.
- R9: The output byte and its valid appear one clock after the input byte. The valid is low in cycles without an input byte.
- R10: Bytes with a channel index of 24 or above, and frames that do not carry signaling in the current mode (for example frame 17 in D4), pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A channel byte is present this cycle |
| frame_idx | input | 5 | 0-based frame index within the multiframe |
| chan_idx | input | 5 | 0-based channel index within the frame |
| byte_in | input | 8 | Channel byte from the stream |
| esf_sel | input | 1 | 1 = ESF, 0 = D4; sampled at boundaries |
| ins_en | input | 1 | Enables replacement of the LSB |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Register write data |
| flag_clr | input | 1 | Clears the multiframe flag |
| byte_out | output | 8 | Channel byte after insertion |
| byte_out_valid | output | 1 | byte_out is valid |
| mf_flag | output | 1 | Sticky multiframe-copy flag |

## Verification
A phase state that has gone wrong shows up in two ways. The flag misbehaves at the very next boundary: it is set where D4 should skip the copy, or stays clear where a copy is due. The LSB in frame 5 or 11 then carries the wrong letter group within a few bytes. A shadow copy that is late or early shows up as an old or new register value in the first signaling frame after the boundary. An address decode error shows up as a wrong bit on one specific channel in one specific frame. The bench therefore probes particular channel and frame pairs whose expected bit differs between the two possible states.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    // Multiframe phase of the inserter
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_ESF   = 2'd1,
        PH_D4_AB = 2'd2,
        PH_D4_CD = 2'd3
    } rbs_phase_e;

    // Distance between signaling frames; a signaling frame is the last of each stride
    localparam int SIG_STRIDE = 6;
endpackage

// File: rtl/rbs_reg_bank.sv
module rbs_reg_bank #(
    parameter int CH_COUNT    = 24,
    parameter int SIG_LETTERS = 4,
    parameter int REG_W       = 8,
    localparam int SIG_BITS   = SIG_LETTERS * CH_COUNT,
    localparam int REG_COUNT  = SIG_BITS / REG_W,
    localparam int ADDR_W     = $clog2(REG_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we_i,
    input  logic [ADDR_W-1:0]   host_addr_i,
    input  logic [REG_W-1:0]    host_wdata_i,
    input  logic                load_i,
    output logic [SIG_BITS-1:0] shadow_o
);
    logic [REG_W-1:0]    regs_q [REG_COUNT];
    logic [SIG_BITS-1:0] regs_flat;
    logic [SIG_BITS-1:0] shadow_q;

    // Host-side bank: an out-of-range address matches no register
    generate
        for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[k] <= '0;
                end else if (host_we_i && host_addr_i == ADDR_W'(k)) begin
                    regs_q[k] <= host_wdata_i;
                end
            end
            assign regs_flat[k*REG_W +: REG_W] = regs_q[k];
        end
    endgenerate

    // Shadow copy at the boundary; takes pre-edge register contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (load_i) begin
            shadow_q <= regs_flat;
        end
    end

    assign shadow_o = shadow_q;

    // R2: the shadow changes only following a load request
    p_shadow_only_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_q) |-> $past(load_i));

    // R1: writes outside the bank leave every register untouched
    p_bad_addr_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we_i && host_addr_i >= ADDR_W'(REG_COUNT)) |=> $stable(regs_flat));
endmodule

// File: rtl/rbs_phase_fsm.sv
module rbs_phase_fsm
    import rbs_pkg::*;
#(
    parameter int FRAME_W = 5,
    parameter int CH_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid_i,
    input  logic [FRAME_W-1:0] frame_idx_i,
    input  logic [CH_W-1:0]    chan_idx_i,
    input  logic               esf_sel_i,
    input  logic               flag_clr_i,
    output rbs_phase_e         phase_o,
    output logic               load_o,
    output logic               flag_o
);
    rbs_phase_e phase_q, phase_d;
    logic       boundary;
    logic       flag_q;

    assign boundary = byte_valid_i && (frame_idx_i == '0) && (chan_idx_i == '0);

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        if (boundary) begin
            unique case (phase_q)
                PH_WAIT, PH_ESF, PH_D4_CD: phase_d = esf_sel_i ? PH_ESF : PH_D4_AB;
                PH_D4_AB:                  phase_d = esf_sel_i ? PH_ESF : PH_D4_CD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_WAIT;
        else        phase_q <= phase_d;
    end

    // Outputs: copy on every boundary except the D4 advance
    always_comb begin
        load_o = 1'b0;
        if (boundary) begin
            unique case (phase_q)
                PH_WAIT, PH_ESF, PH_D4_CD: load_o = 1'b1;
                PH_D4_AB:                  load_o = esf_sel_i;
            endcase
        end
    end

    // Sticky flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (load_o)     flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    assign phase_o = phase_q;
    assign flag_o  = flag_q;

    // R7: a copy always leaves the flag set
    p_flag_set_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> flag_q);

    // R7: without a clear the flag never drops
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);

    // R4: the second D4 boundary advances without a copy
    p_d4_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_D4_AB && boundary && !esf_sel_i) |=> (phase_q == PH_D4_CD && !$rose(flag_q)));

    // R8: selecting ESF at a boundary always lands in the ESF phase
    p_esf_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && esf_sel_i) |=> phase_q == PH_ESF);

    // R2: the phase only moves on a boundary byte
    p_phase_moves_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(phase_q));
endmodule

// File: rtl/rbs_slot_mux.sv
module rbs_slot_mux
    import rbs_pkg::*;
#(
    parameter int CH_COUNT    = 24,
    parameter int SIG_LETTERS = 4,
    parameter int FRAME_W     = 5,
    parameter int CH_W        = 5,
    localparam int SIG_BITS   = SIG_LETTERS * CH_COUNT,
    localparam int LET_W      = $clog2(SIG_LETTERS),
    localparam int D4_LETTERS = SIG_LETTERS / 2,
    localparam int IDX_W      = $clog2(SIG_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_valid_i,
    input  logic [FRAME_W-1:0]  frame_idx_i,
    input  logic [CH_W-1:0]     chan_idx_i,
    input  logic [7:0]          byte_i,
    input  logic                ins_en_i,
    input  rbs_phase_e          phase_i,
    input  logic [SIG_BITS-1:0] shadow_i,
    output logic [7:0]          byte_o,
    output logic                valid_o
);
    logic             hit;
    logic [LET_W-1:0] letter;
    logic [LET_W-1:0] slot;
    logic             use_sig;
    logic [IDX_W-1:0] idx;
    logic [7:0]       byte_d;
    logic [7:0]       byte_q;
    logic             valid_q;

    // Which letter (if any) this frame carries
    always_comb begin
        hit    = 1'b0;
        letter = '0;
        for (int l = 0; l < SIG_LETTERS; l++) begin
            if (frame_idx_i == FRAME_W'(l * SIG_STRIDE + SIG_STRIDE - 1)) begin
                hit    = 1'b1;
                letter = LET_W'(l);
            end
        end
    end

    // Letter group selection per phase
    always_comb begin
        use_sig = 1'b0;
        slot    = letter;
        unique case (phase_i)
            PH_WAIT:  use_sig = 1'b0;
            PH_ESF:   use_sig = hit;
            PH_D4_AB: use_sig = hit && (letter < LET_W'(D4_LETTERS));
            PH_D4_CD: begin
                use_sig = hit && (letter < LET_W'(D4_LETTERS));
                slot    = letter + LET_W'(D4_LETTERS);
            end
        endcase
        use_sig = use_sig && ins_en_i && (chan_idx_i < CH_W'(CH_COUNT));
        idx     = IDX_W'(slot) * IDX_W'(CH_COUNT) + IDX_W'(chan_idx_i);
        byte_d  = use_sig ? {byte_i[7:1], shadow_i[idx]} : byte_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            byte_q  <= byte_d;
            valid_q <= byte_valid_i;
        end
    end

    assign byte_o  = byte_q;
    assign valid_o = valid_q;

    // R5: upper seven bits always reach the output untouched
    p_upper_bits_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_i |=> byte_q[7:1] == $past(byte_i[7:1]));

    // R5: with insertion off the byte is unchanged
    p_pass_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && !ins_en_i) |=> byte_q == $past(byte_i));

    // R6: before the first copy nothing is replaced
    p_pass_before_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && phase_i == PH_WAIT) |=> byte_q == $past(byte_i));

    // R9: one-cycle latency on the valid
    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_i |=> valid_q);
endmodule

// File: rtl/rbs_tx_inserter.sv
module rbs_tx_inserter
    import rbs_pkg::*;
#(
    parameter int CH_COUNT    = 24,
    parameter int SIG_LETTERS = 4,
    parameter int REG_W       = 8,
    localparam int FRAME_W    = $clog2(SIG_LETTERS * SIG_STRIDE),
    localparam int CH_W       = $clog2(CH_COUNT),
    localparam int SIG_BITS   = SIG_LETTERS * CH_COUNT,
    localparam int ADDR_W     = $clog2(SIG_BITS / REG_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic [CH_W-1:0]    chan_idx,
    input  logic [7:0]         byte_in,
    input  logic               esf_sel,
    input  logic               ins_en,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [REG_W-1:0]   host_wdata,
    input  logic               flag_clr,
    output logic [7:0]         byte_out,
    output logic               byte_out_valid,
    output logic               mf_flag
);
    rbs_phase_e          phase;
    logic                load;
    logic [SIG_BITS-1:0] shadow;

    rbs_phase_fsm #(
        .FRAME_W (FRAME_W),
        .CH_W    (CH_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid),
        .frame_idx_i  (frame_idx),
        .chan_idx_i   (chan_idx),
        .esf_sel_i    (esf_sel),
        .flag_clr_i   (flag_clr),
        .phase_o      (phase),
        .load_o       (load),
        .flag_o       (mf_flag)
    );

    rbs_reg_bank #(
        .CH_COUNT    (CH_COUNT),
        .SIG_LETTERS (SIG_LETTERS),
        .REG_W       (REG_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (host_we),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .load_i       (load),
        .shadow_o     (shadow)
    );

    rbs_slot_mux #(
        .CH_COUNT    (CH_COUNT),
        .SIG_LETTERS (SIG_LETTERS),
        .FRAME_W     (FRAME_W),
        .CH_W        (CH_W)
    ) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid),
        .frame_idx_i  (frame_idx),
        .chan_idx_i   (chan_idx),
        .byte_i       (byte_in),
        .ins_en_i     (ins_en),
        .phase_i      (phase),
        .shadow_i     (shadow),
        .byte_o       (byte_out),
        .valid_o      (byte_out_valid)
    );
endmodule

// File: tb/rbs_tx_inserter_tb.sv
module rbs_tx_inserter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_valid;
    logic [4:0] frame_idx;
    logic [4:0] chan_idx;
    logic [7:0] byte_in;
    logic       esf_sel;
    logic       ins_en;
    logic       host_we;
    logic [3:0] host_addr;
    logic [7:0] host_wdata;
    logic       flag_clr;
    logic [7:0] byte_out;
    logic       byte_out_valid;
    logic       mf_flag;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    rbs_tx_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_idx(frame_idx),
        .chan_idx(chan_idx), .byte_in(byte_in), .esf_sel(esf_sel), .ins_en(ins_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .flag_clr(flag_clr), .byte_out(byte_out), .byte_out_valid(byte_out_valid),
        .mf_flag(mf_flag)
    );

    // {frame, channel, input byte, expected byte}; ESF, insertion on
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {5'd5,  5'd0,  8'hFE, 8'hFF},  // A ch0 = 1
        {5'd5,  5'd1,  8'hFF, 8'hFE},  // A ch1 = 0
        {5'd5,  5'd15, 8'h00, 8'h01},  // A ch15 = 1
        {5'd11, 5'd3,  8'h00, 8'h01},  // B ch3 = 1
        {5'd11, 5'd8,  8'h55, 8'h54},  // B ch8 = 0
        {5'd17, 5'd23, 8'hAA, 8'hAB},  // C ch23 = 1
        {5'd17, 5'd22, 8'hAB, 8'hAA},  // C ch22 = 0
        {5'd23, 5'd16, 8'h10, 8'h11},  // D ch16 = 1
        {5'd23, 5'd17, 8'h11, 8'h10},  // D ch17 = 0
        {5'd4,  5'd0,  8'h3C, 8'h3C},  // not a signaling frame
        {5'd6,  5'd0,  8'hC3, 8'hC3},  // not a signaling frame
        {5'd5,  5'd24, 8'h00, 8'h00},  // channel out of range
        {5'd0,  5'd5,  8'h77, 8'h77}   // frame 0, not boundary
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic send(input int f, input int c, input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; frame_idx = 5'(f); chan_idx = 5'(c); byte_in = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; byte_valid = 1'b0; frame_idx = '0; chan_idx = '0; byte_in = '0;
        esf_sel = 1'b1; ins_en = 1'b1; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6/R7/R9 reset state
        chk("R6 reset byte", byte_out, 8'h00);
        chk("R9 reset valid", 8'(byte_out_valid), 8'h00);
        chk("R7 reset flag", 8'(mf_flag), 8'h00);

        host_write(0, 8'h01);
        host_write(1, 8'h80);
        host_write(3, 8'hFF);
        host_write(8, 8'h80);
        host_write(11, 8'h01);

        // R6: no copy yet, so nothing inserted
        send(5, 0, 8'hFE);
        chk("R6 before first load", byte_out, 8'hFE);

        // ESF boundary: copy and flag
        send(0, 0, 8'h5A);
        chk("R7 flag on first load", 8'(mf_flag), 8'h01);
        chk("R10 boundary byte passes", byte_out, 8'h5A);

        // R3/R1/R10 table walk
        for (int i = 0; i < NV; i++) begin
            send(int'(VEC[i][25:21]), int'(VEC[i][20:16]), VEC[i][15:8]);
            chk("R3 table vector", byte_out, VEC[i][7:0]);
        end

        // R9: valid asserted one clock after the byte, then drops
        send(4, 1, 8'h42);
        chk("R9 valid after byte", 8'(byte_out_valid), 8'h01);
        @(negedge clk);
        chk("R9 valid idle", 8'(byte_out_valid), 8'h00);

        // R2: mid-multiframe write is not seen
        host_write(0, 8'h00);
        send(5, 0, 8'hFE);
        chk("R2 write before next load hidden", byte_out, 8'hFF);

        // R2: write in the copy cycle goes to the next copy
        clear_flag();
        @(negedge clk);
        byte_valid = 1'b1; frame_idx = 5'd0; chan_idx = 5'd0; byte_in = 8'h00;
        host_we = 1'b1; host_addr = 4'd0; host_wdata = 8'h01;
        @(negedge clk);
        byte_valid = 1'b0; host_we = 1'b0;
        send(5, 0, 8'hFE);
        chk("R2 copy uses pre-write value", byte_out, 8'hFE);

        // R7: clear then set again
        clear_flag();
        chk("R7 flag cleared", 8'(mf_flag), 8'h00);
        send(0, 0, 8'h00);
        chk("R7 flag set by load", 8'(mf_flag), 8'h01);
        send(5, 0, 8'hFE);
        chk("R2 late write seen at next load", byte_out, 8'hFF);

        // R7: simultaneous clear and copy leaves flag set
        @(negedge clk);
        byte_valid = 1'b1; frame_idx = 5'd0; chan_idx = 5'd0; flag_clr = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; flag_clr = 1'b0;
        chk("R7 set wins over clear", 8'(mf_flag), 8'h01);

        // R5: insertion disabled
        ins_en = 1'b0;
        send(5, 0, 8'hFE);
        chk("R5 disabled passthrough", byte_out, 8'hFE);
        ins_en = 1'b1;

        // R1: out-of-range addresses do not alias
        host_write(12, 8'hFF);
        host_write(15, 8'hFF);
        send(0, 0, 8'h00);
        send(11, 8, 8'h00);
        chk("R1 addr 12 ignored", byte_out, 8'h00);
        send(17, 8, 8'h00);
        chk("R1 addr 15 ignored", byte_out, 8'h00);

        // R4: D4 alternation
        host_write(0, 8'h00);
        host_write(3, 8'h02);
        host_write(6, 8'h01);
        host_write(9, 8'h04);
        esf_sel = 1'b0;
        clear_flag();
        send(0, 0, 8'h00);
        chk("R4 d4 first boundary copies", 8'(mf_flag), 8'h01);
        send(5, 0, 8'hFE);
        chk("R4 d4 A group", byte_out, 8'hFE);
        send(11, 1, 8'h00);
        chk("R4 d4 B group", byte_out, 8'h01);
        send(17, 0, 8'h00);
        chk("R10 frame 17 in D4 passes", byte_out, 8'h00);
        host_write(0, 8'h01);
        clear_flag();
        send(0, 0, 8'h00);
        chk("R4 d4 second boundary no copy", 8'(mf_flag), 8'h00);
        send(5, 0, 8'hFE);
        chk("R4 d4 C as A", byte_out, 8'hFF);
        send(11, 2, 8'h00);
        chk("R4 d4 D as B ch2", byte_out, 8'h01);
        send(11, 1, 8'h00);
        chk("R4 d4 D as B ch1", byte_out, 8'h00);
        send(0, 0, 8'h00);
        chk("R4 d4 third boundary copies", 8'(mf_flag), 8'h01);
        send(5, 0, 8'hFE);
        chk("R4 new A after copy", byte_out, 8'hFF);
        send(11, 2, 8'h00);
        chk("R4 B group again", byte_out, 8'h00);

        // R8: switch to ESF on the boundary that D4 would skip
        esf_sel = 1'b1;
        clear_flag();
        send(0, 0, 8'h00);
        chk("R8 esf switch copies", 8'(mf_flag), 8'h01);
        send(17, 0, 8'h00);
        chk("R8 esf C letter", byte_out, 8'h01);
        send(23, 2, 8'h00);
        chk("R8 esf D letter", byte_out, 8'h01);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule